// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block holds a small table of VLAN entries. Each entry pairs a 12-bit VLAN identifier with a 10-bit bitmap of member ports. Software never writes the table storage directly. It first writes a data register with the member bitmap, then writes a command register with the go bit set. A sequencer then walks the table one slot per cycle and applies the command: do nothing, invalidate everything, insert or overwrite an entry, invalidate one entry, or strip one port from every entry. While the walk runs, the go bit reads back as an active flag. When the walk ends, the flag drops by itself. A load that finds neither a matching entry nor a free slot raises a full flag and leaves the table untouched.

A separate lookup port lets the forwarding logic present a VLAN identifier. One cycle later it receives a hit flag and the member bitmap for that identifier. A miss returns an all-zero bitmap.

The sequencer has three states:
- IDLE waits for an accepted command (IDLE to SCAN).
- SCAN visits slot 0 through the last slot. On the last slot it moves to COMMIT if the operation is a load, and back to IDLE for any other operation.
- COMMIT writes the load result or raises the full flag, then returns to IDLE.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset the command readback word is all zero, and every lookup misses with a zero bitmap.
- R2: A command starts only when the command register is written with bit 3 set while the engine is idle. A command-register write with bit 3 clear has no effect. A command-register write made while a command is running has no effect. Data-register writes are taken only while idle.
- R3: Opcode field bits [2:0] encode 0 no-op, 1 flush, 2 load, 3 purge and 4 remove-port. Codes 5 to 7 behave as no-op. Bit 3 of the readback reads 1 while a command runs. It stays high for exactly 16 cycles for a non-load command and for 17 cycles for a load, then clears by itself.
- R4: A load of a VLAN ID (command bits [27:16]) that is not in the table places that ID in the lowest free slot. The member bitmap is taken from data-register bits [9:0]. The new entry is valid whatever the value of data-register bit 11.
- R5: A load of a VLAN ID already in the table replaces that entry's bitmap and uses no further slot.
- R6: A load of a new ID when all 16 slots are valid sets the full flag (readback bit 4) and leaves the table unchanged. The next accepted command clears the flag.
- R7: Purge invalidates the entry whose ID matches and leaves every other entry intact. Purge of an absent ID changes nothing.
- R8: Remove-port clears the bit selected by command bits [11:8] in the bitmap of every valid entry. A port number of 10 or more changes nothing.
- R9: Flush invalidates every entry.
- R10: A lookup request is answered on the following cycle with a valid strobe, a hit flag and the bitmap. A miss returns a zero bitmap.
- R11: The readback word echoes the last accepted command. The layout is: opcode [2:0], active 3, full 4, port [11:8], ID [27:16], priority [30:28] and priority-enable bit 31. All other bits read 0.
- R12: A no-op command leaves every table entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command register write value |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 32 | Data register write value |
| cmd_rdata | output | 32 | Command register readback with active and full flags |
| lkp_req | input | 1 | Lookup request |
| lkp_vid | input | 12 | VLAN ID to look up |
| lkp_valid | output | 1 | Lookup answer strobe |
| lkp_hit | output | 1 | Lookup found a valid entry |
| lkp_members | output | 10 | Member bitmap of the found entry, zero on a miss |

## Verification
The assertions assume that software follows the register protocol. The go bit is set only to start a command, and a new command is normally issued only after active has been seen clear. They also assume that a lookup request is a single-cycle pulse. The stimulus polls the active bit after each command before it issues the next one. The only exception is one deliberate write made during a running command, which tests that such a write is ignored. Lookups are issued only while the engine is idle, so each answer matches a settled table that the bench models from the requirements alone.

// File: rtl/vlan_eng_pkg.sv
package vlan_eng_pkg;

    localparam int VID_W  = 12;
    localparam int PMAP_W = 10;
    localparam int PORT_W = 4;
    localparam int PRIO_W = 3;
    localparam int OP_W   = 3;

    // Command word field positions (software-visible layout)
    localparam int F_OP_LSB   = 0;
    localparam int F_GO_BIT   = 3;
    localparam int F_FULL_BIT = 4;
    localparam int F_PORT_LSB = 8;
    localparam int F_VID_LSB  = 16;
    localparam int F_PRIO_LSB = 28;
    localparam int F_PEN_BIT  = 31;

    typedef enum logic [OP_W-1:0] {
        OP_NOP    = 3'd0,
        OP_FLUSH  = 3'd1,
        OP_LOAD   = 3'd2,
        OP_PURGE  = 3'd3,
        OP_RMPORT = 3'd4
    } vtu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_COMMIT = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic              valid;
        logic [VID_W-1:0]  vid;
        logic [PMAP_W-1:0] members;
    } vtu_entry_t;

endpackage

// File: rtl/vlan_table_store.sv
module vlan_table_store
    import vlan_eng_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  vtu_entry_t                   wr_entry,
    output vtu_entry_t [NUM_SLOTS-1:0]   table_q
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                table_q[s] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(s))) begin
                table_q[s] <= wr_entry;
            end
        end

        // R4: a write aimed at this slot is what the slot holds next cycle
        a_r4_slot_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(s)) |=> (table_q[s] == $past(wr_entry)));

        // R12: slots not written keep their contents
        a_r12_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IDX_W'(s)) |=> $stable(table_q[s]));
    end

endmodule

// File: rtl/vlan_lookup.sv
module vlan_lookup
    import vlan_eng_pkg::*;
#(
    parameter int NUM_SLOTS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic [VID_W-1:0]            vid,
    input  vtu_entry_t [NUM_SLOTS-1:0]  table_q,
    output logic                        rsp_valid,
    output logic                        rsp_hit,
    output logic [PMAP_W-1:0]           rsp_members
);

    logic              hit_c;
    logic [PMAP_W-1:0] mem_c;

    // Lowest matching slot wins; the engine never keeps duplicate IDs.
    always_comb begin
        hit_c = 1'b0;
        mem_c = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (table_q[s].valid && table_q[s].vid == vid) begin
                hit_c = 1'b1;
                mem_c = table_q[s].members;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_members <= '0;
        end else begin
            rsp_valid   <= req;
            rsp_hit     <= req & hit_c;
            rsp_members <= req ? mem_c : '0;
        end
    end

    a_r10_answer_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);

    a_r10_miss_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_members == '0));

endmodule

// File: rtl/vlan_cmd_fsm.sv
module vlan_cmd_fsm
    import vlan_eng_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int CNT_W = $clog2(NUM_SLOTS + 3)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_wr,
    input  logic [31:0]                 cmd_wdata,
    input  logic                        data_wr,
    input  logic [31:0]                 data_wdata,
    input  vtu_entry_t [NUM_SLOTS-1:0]  table_q,
    output logic                        wr_en,
    output logic [IDX_W-1:0]            wr_idx,
    output vtu_entry_t                  wr_entry,
    output logic [31:0]                 cmd_rdata
);

    eng_state_e        state_q, state_d;
    logic [IDX_W-1:0]  scan_q;
    logic [OP_W-1:0]   op_q;
    logic [VID_W-1:0]  vid_q;
    logic [PORT_W-1:0] port_q;
    logic [PRIO_W-1:0] prio_q;
    logic              pen_q;
    logic              full_q;
    logic [PMAP_W-1:0] data_q;
    logic              hit_found_q, free_found_q;
    logic [IDX_W-1:0]  hit_idx_q, free_idx_q;

    logic              start;
    logic              last_slot;
    vtu_entry_t        cur;
    logic              cur_match;
    logic [PMAP_W-1:0] port_mask;
    logic              unused_wbits;

    assign unused_wbits = ^{cmd_wdata[15:12], cmd_wdata[7:4], data_wdata[31:PMAP_W]};

    assign start     = cmd_wr && cmd_wdata[F_GO_BIT] && (state_q == ST_IDLE);
    assign last_slot = (scan_q == IDX_W'(NUM_SLOTS - 1));
    assign cur       = table_q[scan_q];
    assign cur_match = cur.valid && (cur.vid == vid_q);
    assign port_mask = (int'(port_q) < PMAP_W) ? (PMAP_W'(1) << port_q) : '0;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SCAN;
            ST_SCAN:   if (last_slot) state_d = (op_q == OP_LOAD) ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Command fields, scan pointer and load bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_q       <= '0;
            op_q         <= '0;
            vid_q        <= '0;
            port_q       <= '0;
            prio_q       <= '0;
            pen_q        <= 1'b0;
            full_q       <= 1'b0;
            data_q       <= '0;
            hit_found_q  <= 1'b0;
            free_found_q <= 1'b0;
            hit_idx_q    <= '0;
            free_idx_q   <= '0;
        end else begin
            if (data_wr && state_q == ST_IDLE) begin
                data_q <= data_wdata[PMAP_W-1:0];
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q         <= cmd_wdata[F_OP_LSB +: OP_W];
                        port_q       <= cmd_wdata[F_PORT_LSB +: PORT_W];
                        vid_q        <= cmd_wdata[F_VID_LSB +: VID_W];
                        prio_q       <= cmd_wdata[F_PRIO_LSB +: PRIO_W];
                        pen_q        <= cmd_wdata[F_PEN_BIT];
                        full_q       <= 1'b0;
                        scan_q       <= '0;
                        hit_found_q  <= 1'b0;
                        free_found_q <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    scan_q <= scan_q + 1'b1;
                    if (op_q == OP_LOAD) begin
                        if (cur_match && !hit_found_q) begin
                            hit_found_q <= 1'b1;
                            hit_idx_q   <= scan_q;
                        end
                        if (!cur.valid && !free_found_q) begin
                            free_found_q <= 1'b1;
                            free_idx_q   <= scan_q;
                        end
                    end
                end
                ST_COMMIT: begin
                    if (!hit_found_q && !free_found_q) full_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Table write port and readback outputs
    always_comb begin
        wr_en    = 1'b0;
        wr_idx   = scan_q;
        wr_entry = cur;
        unique case (state_q)
            ST_SCAN: begin
                case (op_q)
                    OP_FLUSH: begin
                        wr_en    = 1'b1;
                        wr_entry = '0;
                    end
                    OP_PURGE: begin
                        if (cur_match) begin
                            wr_en          = 1'b1;
                            wr_entry.valid = 1'b0;
                        end
                    end
                    OP_RMPORT: begin
                        if (cur.valid) begin
                            wr_en            = 1'b1;
                            wr_entry.members = cur.members & ~port_mask;
                        end
                    end
                    default: ;
                endcase
            end
            ST_COMMIT: begin
                wr_entry = '{valid: 1'b1, vid: vid_q, members: data_q};
                if (hit_found_q) begin
                    wr_en  = 1'b1;
                    wr_idx = hit_idx_q;
                end else if (free_found_q) begin
                    wr_en  = 1'b1;
                    wr_idx = free_idx_q;
                end
            end
            default: ;
        endcase

        cmd_rdata = '0;
        cmd_rdata[F_OP_LSB +: OP_W]       = op_q;
        cmd_rdata[F_GO_BIT]               = (state_q != ST_IDLE);
        cmd_rdata[F_FULL_BIT]             = full_q;
        cmd_rdata[F_PORT_LSB +: PORT_W]   = port_q;
        cmd_rdata[F_VID_LSB +: VID_W]     = vid_q;
        cmd_rdata[F_PRIO_LSB +: PRIO_W]   = prio_q;
        cmd_rdata[F_PEN_BIT]              = pen_q;
    end

    // Busy-window counter used only by the duration check below
    logic [CNT_W-1:0] busy_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 busy_cnt <= '0;
        else if (state_q == ST_IDLE) busy_cnt <= '0;
        else                        busy_cnt <= busy_cnt + 1'b1;
    end

    a_r3_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= CNT_W'(NUM_SLOTS + 1));

    a_r2_idle_without_go: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !(cmd_wr && cmd_wdata[F_GO_BIT])) |=> (state_q == ST_IDLE));

    a_r2_fields_stable_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(vid_q) && $stable(op_q) && $stable(data_q)));

    a_r6_full_only_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_q) |-> ($past(state_q) == ST_COMMIT));

endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
    import vlan_eng_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic [31:0]          cmd_wdata,
    input  logic                 data_wr,
    input  logic [31:0]          data_wdata,
    output logic [31:0]          cmd_rdata,
    input  logic                 lkp_req,
    input  logic [VID_W-1:0]     lkp_vid,
    output logic                 lkp_valid,
    output logic                 lkp_hit,
    output logic [PMAP_W-1:0]    lkp_members
);

    vtu_entry_t [NUM_SLOTS-1:0] table_q;
    logic                       wr_en;
    logic [IDX_W-1:0]           wr_idx;
    vtu_entry_t                 wr_entry;

    vlan_cmd_fsm #(.NUM_SLOTS(NUM_SLOTS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_wdata  (cmd_wdata),
        .data_wr    (data_wr),
        .data_wdata (data_wdata),
        .table_q    (table_q),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_entry   (wr_entry),
        .cmd_rdata  (cmd_rdata)
    );

    vlan_table_store #(.NUM_SLOTS(NUM_SLOTS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .table_q  (table_q)
    );

    vlan_lookup #(.NUM_SLOTS(NUM_SLOTS)) u_lookup (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (lkp_req),
        .vid         (lkp_vid),
        .table_q     (table_q),
        .rsp_valid   (lkp_valid),
        .rsp_hit     (lkp_hit),
        .rsp_members (lkp_members)
    );

    // R6: a full flag never appears while a command is still running
    a_r6_full_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rdata[4] |-> !cmd_rdata[3]);

endmodule

// File: tb/vlan_cmd_engine_bench.sv
module vlan_cmd_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        data_wr = 1'b0;
    logic [31:0] data_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        lkp_req = 1'b0;
    logic [11:0] lkp_vid = '0;
    logic        lkp_valid, lkp_hit;
    logic [9:0]  lkp_members;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlan_cmd_engine u_vlan_cmd_engine (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .data_wr(data_wr), .data_wdata(data_wdata), .cmd_rdata(cmd_rdata),
        .lkp_req(lkp_req), .lkp_vid(lkp_vid), .lkp_valid(lkp_valid),
        .lkp_hit(lkp_hit), .lkp_members(lkp_members)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Reference table, maintained from the requirements
    logic        m_valid [SLOTS];
    logic [11:0] m_vid   [SLOTS];
    logic [9:0]  m_mem   [SLOTS];
    logic [9:0]  m_data;
    logic        m_full;

    // Scoreboard queues
    logic        exp_hit_q [$];
    logic [9:0]  exp_mem_q [$];
    string       exp_tag_q [$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expectation per lookup answer
    always @(negedge clk) begin
        if (rst_n && lkp_valid) begin
            if (exp_hit_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R10 unexpected answer actual=%0b expected=none", lkp_hit);
            end else begin
                logic       eh;
                logic [9:0] em;
                string      et;
                eh = exp_hit_q.pop_front();
                em = exp_mem_q.pop_front();
                et = exp_tag_q.pop_front();
                chk({et, " hit"}, {31'd0, lkp_hit}, {31'd0, eh});
                chk({et, " members"}, {22'd0, lkp_members}, {22'd0, em});
            end
        end
    end

    function automatic void model_find(input logic [11:0] v, output logic h, output logic [9:0] m);
        h = 1'b0; m = '0;
        for (int s = SLOTS - 1; s >= 0; s--)
            if (m_valid[s] && m_vid[s] == v) begin h = 1'b1; m = m_mem[s]; end
    endfunction

    task automatic lookup(input logic [11:0] v, input string tag);
        logic       h;
        logic [9:0] m;
        model_find(v, h, m);
        exp_hit_q.push_back(h);
        exp_mem_q.push_back(m);
        exp_tag_q.push_back(tag);
        @(posedge clk); #1;
        lkp_req = 1'b1; lkp_vid = v;
        @(posedge clk); #1;
        lkp_req = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic set_data(input logic [9:0] mem, input logic vbit);
        @(posedge clk); #1;
        data_wr = 1'b1; data_wdata = {20'd0, vbit, 1'b0, mem};
        @(posedge clk); #1;
        data_wr = 1'b0;
        m_data = mem;
    endtask

    function automatic void model_apply(input logic [2:0] op, input logic [11:0] v, input logic [3:0] p);
        int hit_i, free_i;
        m_full = 1'b0;
        case (op)
            3'd1: for (int s = 0; s < SLOTS; s++) m_valid[s] = 1'b0;
            3'd2: begin
                hit_i = -1; free_i = -1;
                for (int s = 0; s < SLOTS; s++) begin
                    if (hit_i < 0 && m_valid[s] && m_vid[s] == v) hit_i = s;
                    if (free_i < 0 && !m_valid[s]) free_i = s;
                end
                if (hit_i >= 0) m_mem[hit_i] = m_data;
                else if (free_i >= 0) begin
                    m_valid[free_i] = 1'b1; m_vid[free_i] = v; m_mem[free_i] = m_data;
                end else m_full = 1'b1;
            end
            3'd3: for (int s = 0; s < SLOTS; s++) if (m_valid[s] && m_vid[s] == v) m_valid[s] = 1'b0;
            3'd4: if (p < 10) for (int s = 0; s < SLOTS; s++) if (m_valid[s]) m_mem[s][p] = 1'b0;
            default: ;
        endcase
    endfunction

    function automatic logic [31:0] cmd_word(input logic [2:0] op, input logic [11:0] v,
                                             input logic [3:0] p, input logic [2:0] pr,
                                             input logic pe, input logic go);
        return {pe, pr, v, 4'd0, p, 3'd0, 1'b0, go, op};
    endfunction

    task automatic run_cmd(input logic [2:0] op, input logic [11:0] v, input logic [3:0] p,
                           input logic [2:0] pr, input logic pe, output int busy);
        @(posedge clk); #1;
        cmd_wr = 1'b1; cmd_wdata = cmd_word(op, v, p, pr, pe, 1'b1);
        @(posedge clk); #1;
        cmd_wr = 1'b0;
        busy = 0;
        while (cmd_rdata[3] && busy < 100) begin
            busy++;
            @(posedge clk); #1;
        end
        model_apply(op, v, p);
    endtask

    function automatic logic [9:0] pat(input int k);
        return 10'((k * 73 + 5) & 10'h3ff);
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int busy;
        for (int s = 0; s < SLOTS; s++) begin m_valid[s] = 1'b0; m_vid[s] = '0; m_mem[s] = '0; end
        m_data = '0; m_full = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 readback after reset", cmd_rdata, 32'd0);
        lookup(12'd5, "R1 lookup after reset");

        // R4 load new ID, data bit 11 clear; R3 load duration; R11 readback
        set_data(10'h155, 1'b0);
        run_cmd(3'd2, 12'd100, 4'd3, 3'd5, 1'b1, busy);
        chk("R3 load busy cycles", busy, SLOTS + 1);
        chk("R11 readback fields", cmd_rdata, cmd_word(3'd2, 12'd100, 4'd3, 3'd5, 1'b1, 1'b0));
        lookup(12'd100, "R4 new entry");

        // R5 overwrite existing ID
        set_data(10'h2aa, 1'b1);
        run_cmd(3'd2, 12'd100, 4'd0, 3'd0, 1'b0, busy);
        lookup(12'd100, "R5 overwrite");

        // Fill remaining 15 slots
        for (int k = 1; k < SLOTS; k++) begin
            set_data(pat(k), 1'b1);
            run_cmd(3'd2, 12'(k), 4'd0, 3'd0, 1'b0, busy);
        end
        chk("R5 no full after 16 distinct", {31'd0, cmd_rdata[4]}, 32'd0);
        lookup(12'd15, "R4 last slot");

        // R6 table full
        set_data(10'h3ff, 1'b1);
        run_cmd(3'd2, 12'd999, 4'd0, 3'd0, 1'b0, busy);
        chk("R6 full flag set", {31'd0, cmd_rdata[4]}, 32'd1);
        lookup(12'd999, "R6 rejected ID absent");
        lookup(12'd1, "R6 table unchanged");

        // R12 / R3 no-op; R6 full clears
        run_cmd(3'd0, 12'd0, 4'd0, 3'd0, 1'b0, busy);
        chk("R3 no-op busy cycles", busy, SLOTS);
        chk("R6 full cleared by next command", {31'd0, cmd_rdata[4]}, 32'd0);
        lookup(12'd7, "R12 entry after no-op");
        run_cmd(3'd6, 12'd7, 4'd0, 3'd0, 1'b0, busy);
        chk("R3 undefined op busy", busy, SLOTS);
        lookup(12'd7, "R3 undefined op harmless");

        // R2 write without go bit
        @(posedge clk); #1;
        cmd_wr = 1'b1; cmd_wdata = cmd_word(3'd1, 12'd55, 4'd2, 3'd1, 1'b1, 1'b0);
        @(posedge clk); #1;
        cmd_wr = 1'b0;
        chk("R2 no start without go", cmd_rdata, cmd_word(3'd6, 12'd7, 4'd0, 3'd0, 1'b0, 1'b0));
        lookup(12'd100, "R2 flush without go ignored");

        // R2 write during a running command; R7 purge
        @(posedge clk); #1;
        cmd_wr = 1'b1; cmd_wdata = cmd_word(3'd3, 12'd1, 4'd0, 3'd0, 1'b0, 1'b1);
        @(posedge clk); #1;
        cmd_wdata = cmd_word(3'd1, 12'd0, 4'd0, 3'd0, 1'b0, 1'b1);
        data_wr = 1'b1; data_wdata = 32'h0000_0001;
        @(posedge clk); #1;
        cmd_wr = 1'b0; data_wr = 1'b0;
        busy = 2;
        while (cmd_rdata[3] && busy < 100) begin busy++; @(posedge clk); #1; end
        model_apply(3'd3, 12'd1, 4'd0);
        chk("R2 busy write ignored readback", cmd_rdata[2:0], 32'd3);
        lookup(12'd1, "R7 purged entry");
        lookup(12'd2, "R2 flush during busy ignored");

        // R7 purge absent ID
        run_cmd(3'd3, 12'd777, 4'd0, 3'd0, 1'b0, busy);
        lookup(12'd2, "R7 absent purge");

        // R4 lowest free slot reuse, data write during busy ignored
        run_cmd(3'd2, 12'd300, 4'd0, 3'd0, 1'b0, busy);
        lookup(12'd300, "R4 reuse freed slot");

        // R8 remove port
        run_cmd(3'd4, 12'd0, 4'd1, 3'd0, 1'b0, busy);
        lookup(12'd100, "R8 port1 cleared");
        lookup(12'd3, "R8 port1 cleared other");
        run_cmd(3'd4, 12'd0, 4'd9, 3'd0, 1'b0, busy);
        lookup(12'd9, "R8 port9 cleared");
        run_cmd(3'd4, 12'd0, 4'd12, 3'd0, 1'b0, busy);
        lookup(12'd4, "R8 port12 no effect");

        // R9 flush
        run_cmd(3'd1, 12'd0, 4'd0, 3'd0, 1'b0, busy);
        chk("R3 flush busy cycles", busy, SLOTS);
        lookup(12'd100, "R9 flushed");
        lookup(12'd15, "R9 flushed last");

        repeat (3) @(posedge clk);
        if (exp_hit_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R10 missing answers actual=%0d expected=0", exp_hit_q.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule